// File: doc/BRIEF.md
# Downstream Command Register Block

This block is the software-facing register set for sending one command at a time to a serial peripheral target. Software fills a set of command words over a 32-bit register bus and writes the first command word with its start bit set. That write launches the command. The block then shows the command words to a link engine through a level request. The link engine answers with a one-cycle response that carries error flags and, for a read of target configuration, a 32-bit value.

The start bit reads back as a busy flag, and the hardware clears it when the response arrives. Each response also sets sticky status flags: a completion flag plus one flag for each kind of error. Software clears these flags by writing ones to them. An interrupt line stays high while any status flag is set. When a configuration read finishes without error, the value it returns replaces the second command word, so software reads the result at the same offset it wrote.

Top module: `dncmd_regif`

## Requirements
- R1: After reset, every register reads 0, and `lnk_req` and `irq` are low.
- R2: The command words sit at byte offsets 0x00 (word 0), 0x04 (word 1), 0x08 (word 2) and 0x0C (payload word), and each reads back what was written. Word 0 holds the command kind in bits 2:0, the busy/start flag in bit 3, the target select in bits 5:4 and three header bytes in bits 31:8. Bits 7:6 of word 0 always read 0. A read returns data in `bus_rdata` on the clock edge that samples `bus_rd`.
- R3: Writing word 0 with bit 3 set launches a command. From the next cycle, `lnk_req` is high, bit 3 reads 1, and `lnk_hdr0`..`lnk_data` carry the stored words (word 0 with bit 3 set).
- R4: Writing word 0 with bit 3 clear stores bits 31:8, 5:4 and 2:0 and does not launch a command.
- R5: While busy, writes to offsets 0x00–0x0C are ignored.
- R6: A `lnk_rsp` pulse while busy clears the busy flag and drops `lnk_req` from the next cycle. Without a response, busy stays set.
- R7: Each accepted response sets status bit 28 (complete) in the status register at 0x70. The error inputs map as follows: `lnk_err[5]` to bit 6 (non-fatal), [4] to bit 5 (fatal), [3] to bit 4 (no response), [2] to bit 2 (CRC), [1] to bit 1 (wait timeout) and [0] to bit 0 (bus error). All other status bits read 0.
- R8: Writing 0x70 clears exactly the status bits written as 1. If a response sets a bit in the same cycle that a write clears it, the bit ends up set.
- R9: When an accepted response has `lnk_err` all zero and the command kind is 1 (configuration read), word 1 takes `lnk_rdata`. For every other kind, and for any error, word 1 is unchanged.
- R10: `irq` is high exactly while some status bit is set, and it rises only after an accepted response.
- R11: A `lnk_rsp` pulse while idle changes no register and does not raise `irq`.
- R12: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| lnk_req | output | 1 | Command pending for the link engine |
| lnk_hdr0 | output | 32 | Command word 0 |
| lnk_hdr1 | output | 32 | Command word 1 |
| lnk_hdr2 | output | 32 | Command word 2 |
| lnk_data | output | 32 | Payload word |
| lnk_rsp | input | 1 | One-cycle response strobe |
| lnk_err | input | 6 | Error flags returned with the response |
| lnk_rdata | input | 32 | Configuration value returned with the response |
| irq | output | 1 | Status-pending interrupt |

## Verification
The assertions check on every cycle that busy holds until a response and drops right after one. They also check that command words do not move under a write while busy, that an idle response changes nothing, that completion is set after each accepted response, that a write-one clear takes effect, and that the interrupt rises only after a response. Three things only the bench scenarios can show, because they depend on the values involved: the exact bit mapping of each error flag, the choice between loading word 1 with returned data and leaving it alone for each command kind, and set winning over a clear in the same cycle. The bench sweeps every command kind and target select with varied error patterns.

// File: rtl/dncmd_pkg.sv
package dncmd_pkg;
  localparam int unsigned OFS_HDR0 = 32'h00;
  localparam int unsigned OFS_HDR1 = 32'h04;
  localparam int unsigned OFS_HDR2 = 32'h08;
  localparam int unsigned OFS_DATA = 32'h0C;
  localparam int unsigned OFS_STAT = 32'h70;

  localparam int unsigned ERR_W    = 6;
  localparam int unsigned BUSY_BIT = 3;
  localparam int unsigned DONE_BIT = 28;

  localparam logic [31:0] HDR0_KEEP = 32'hFFFF_FF37;
  localparam logic [31:0] STAT_MASK = 32'h1000_0077;

  typedef enum logic [2:0] {
    CK_SETCFG = 3'd0,
    CK_GETCFG = 3'd1,
    CK_LNKRST = 3'd2,
    CK_RSVD3  = 3'd3,
    CK_PERIPH = 3'd4,
    CK_VWIRE  = 3'd5,
    CK_SIDEBD = 3'd6,
    CK_FLASH  = 3'd7
  } cmd_kind_e;

  function automatic logic [31:0] err_to_stat(input logic [ERR_W-1:0] e);
    logic [31:0] v;
    v           = '0;
    v[DONE_BIT] = 1'b1;
    v[6]        = e[5];
    v[5]        = e[4];
    v[4]        = e[3];
    v[2]        = e[2];
    v[1]        = e[1];
    v[0]        = e[0];
    return v;
  endfunction
endpackage

// File: rtl/dncmd_rst_sync.sv
module dncmd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/dncmd_cmd_regs.sv
module dncmd_cmd_regs
  import dncmd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              rsp_valid,
  input  logic [ERR_W-1:0]  rsp_err,
  input  logic [31:0]       rsp_data,
  output logic              busy,
  output logic              done,
  output logic [31:0]       hdr0,
  output logic [31:0]       hdr1,
  output logic [31:0]       hdr2,
  output logic [31:0]       data
);
  localparam logic [ADDR_W-1:0] A_H0 = ADDR_W'(OFS_HDR0);
  localparam logic [ADDR_W-1:0] A_H1 = ADDR_W'(OFS_HDR1);
  localparam logic [ADDR_W-1:0] A_H2 = ADDR_W'(OFS_HDR2);
  localparam logic [ADDR_W-1:0] A_DT = ADDR_W'(OFS_DATA);

  logic        busy_q, busy_d;
  logic [31:0] h0_q, h0_d, h1_q, h1_d, h2_q, dt_q;
  logic        wr_open, load_cfg;
  logic        en_h0, en_h1, en_h2, en_dt;

  // next-state
  always_comb begin
    wr_open  = wr_en & ~busy_q;
    done     = busy_q & rsp_valid;
    load_cfg = done && (h0_q[2:0] == CK_GETCFG) && (rsp_err == '0);
    en_h0    = wr_open && (addr == A_H0);
    en_h1    = (wr_open && (addr == A_H1)) || load_cfg;
    en_h2    = wr_open && (addr == A_H2);
    en_dt    = wr_open && (addr == A_DT);
    h0_d     = wdata & HDR0_KEEP;
    h1_d     = load_cfg ? rsp_data : wdata;
    busy_d   = busy_q;
    if (done)       busy_d = 1'b0;
    else if (en_h0) busy_d = wdata[BUSY_BIT];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      h0_q   <= '0;
      h1_q   <= '0;
      h2_q   <= '0;
      dt_q   <= '0;
    end else begin
      busy_q <= busy_d;
      if (en_h0) h0_q <= h0_d;
      if (en_h1) h1_q <= h1_d;
      if (en_h2) h2_q <= wdata;
      if (en_dt) dt_q <= wdata;
    end
  end

  assign busy = busy_q;
  assign hdr0 = h0_q | (32'(busy_q) << BUSY_BIT);
  assign hdr1 = h1_q;
  assign hdr2 = h2_q;
  assign data = dt_q;

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !rsp_valid |=> busy_q); // R6
  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && rsp_valid |=> !busy_q); // R6
  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && wr_en && !rsp_valid |=> $stable(h0_q) && $stable(h1_q) && $stable(h2_q) && $stable(dt_q)); // R5
  AST_IDLE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && rsp_valid && !wr_en |=> !busy_q && $stable(h1_q)); // R11
endmodule

// File: rtl/dncmd_status.sv
module dncmd_status
  import dncmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [ERR_W-1:0] rsp_err,
  input  logic             clr_en,
  input  logic [31:0]      clr_bits,
  output logic [31:0]      stat,
  output logic             irq
);
  logic [31:0] st_q, st_d;
  logic        st_en;

  always_comb begin
    st_en = set_en | clr_en;
    st_d  = st_q & ~(clr_en ? clr_bits : 32'h0);
    if (set_en) st_d = st_d | err_to_stat(rsp_err);
    st_d  = st_d & STAT_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  assign stat = st_q;
  assign irq  = |st_q;

  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> st_q[DONE_BIT]); // R7
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && clr_bits[DONE_BIT] && !set_en |=> !st_q[DONE_BIT]); // R8
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(set_en)); // R10
endmodule

// File: rtl/dncmd_regif.sv
module dncmd_regif
  import dncmd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              lnk_req,
  output logic [31:0]       lnk_hdr0,
  output logic [31:0]       lnk_hdr1,
  output logic [31:0]       lnk_hdr2,
  output logic [31:0]       lnk_data,
  input  logic              lnk_rsp,
  input  logic [ERR_W-1:0]  lnk_err,
  input  logic [31:0]       lnk_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_H0 = ADDR_W'(OFS_HDR0);
  localparam logic [ADDR_W-1:0] A_H1 = ADDR_W'(OFS_HDR1);
  localparam logic [ADDR_W-1:0] A_H2 = ADDR_W'(OFS_HDR2);
  localparam logic [ADDR_W-1:0] A_DT = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(OFS_STAT);

  logic        rst_n_s, busy, done;
  logic [31:0] hdr0, hdr1, hdr2, data, stat, rd_d, rd_q;

  dncmd_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  dncmd_cmd_regs #(.ADDR_W(ADDR_W)) cmd_i (
    .clk(clk), .rst_n(rst_n_s), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rsp_valid(lnk_rsp), .rsp_err(lnk_err),
    .rsp_data(lnk_rdata), .busy(busy), .done(done),
    .hdr0(hdr0), .hdr1(hdr1), .hdr2(hdr2), .data(data)
  );

  dncmd_status st_i (
    .clk(clk), .rst_n(rst_n_s), .set_en(done), .rsp_err(lnk_err),
    .clr_en(bus_wr && (bus_addr == A_ST)), .clr_bits(bus_wdata),
    .stat(stat), .irq(irq)
  );

  always_comb begin
    case (bus_addr)
      A_H0:    rd_d = hdr0;
      A_H1:    rd_d = hdr1;
      A_H2:    rd_d = hdr2;
      A_DT:    rd_d = data;
      A_ST:    rd_d = stat;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    rd_q <= '0;
    else if (bus_rd) rd_q <= rd_d;
  end

  assign bus_rdata = rd_q;
  assign lnk_req   = busy;
  assign lnk_hdr0  = hdr0;
  assign lnk_hdr1  = hdr1;
  assign lnk_hdr2  = hdr2;
  assign lnk_data  = data;
endmodule

// File: tb/dncmd_regif_tb.sv
module dncmd_regif_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        lnk_req, irq;
  logic [31:0] lnk_hdr0, lnk_hdr1, lnk_hdr2, lnk_data;
  logic        lnk_rsp = 1'b0;
  logic [5:0]  lnk_err = '0;
  logic [31:0] lnk_rdata = '0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dncmd_regif dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lnk_req(lnk_req), .lnk_hdr0(lnk_hdr0), .lnk_hdr1(lnk_hdr1),
    .lnk_hdr2(lnk_hdr2), .lnk_data(lnk_data), .lnk_rsp(lnk_rsp),
    .lnk_err(lnk_err), .lnk_rdata(lnk_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic rsp(input logic [5:0] e, input logic [31:0] d);
    @(negedge clk); lnk_rsp = 1'b1; lnk_err = e; lnk_rdata = d;
    @(negedge clk); lnk_rsp = 1'b0; lnk_err = '0;
  endtask

  function automatic logic [31:0] exp_stat(input logic [5:0] e);
    return 32'h1000_0000 | (32'(e[5]) << 6) | (32'(e[4]) << 5) | (32'(e[3]) << 4)
         | (32'(e[2]) << 2) | (32'(e[1]) << 1) | 32'(e[0]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    foreach (v[i]) begin end
    rd(8'h00, v); chk("R1 hdr0", v, 0);
    rd(8'h04, v); chk("R1 hdr1", v, 0);
    rd(8'h08, v); chk("R1 hdr2", v, 0);
    rd(8'h0C, v); chk("R1 data", v, 0);
    rd(8'h70, v); chk("R1 stat", v, 0);
    chk("R1 req", 32'(lnk_req), 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 / R4 storage and reserved bits
    wr(8'h04, 32'h1122_3344); wr(8'h08, 32'h5566_7788); wr(8'h0C, 32'h99AA_BBCC);
    rd(8'h04, v); chk("R2 hdr1", v, 32'h1122_3344);
    rd(8'h08, v); chk("R2 hdr2", v, 32'h5566_7788);
    rd(8'h0C, v); chk("R2 data", v, 32'h99AA_BBCC);
    wr(8'h00, 32'hFFFF_FFF7);
    rd(8'h00, v); chk("R2 R4 hdr0 rsvd", v, 32'hFFFF_FF37);
    chk("R4 no launch", 32'(lnk_req), 0);

    // R12 unmapped
    rd(8'h10, v); chk("R12 0x10", v, 0);
    rd(8'h74, v); chk("R12 0x74", v, 0);
    rd(8'hFC, v); chk("R12 0xFC", v, 0);

    // sweep every kind and target
    for (int i = 0; i < 32; i++) begin
      logic [2:0]  ty;
      logic [1:0]  tg;
      logic [23:0] hb;
      logic [5:0]  e;
      logic [31:0] h0, pre, ret;
      ty  = 3'(i % 8);
      tg  = 2'(i / 8);
      hb  = 24'(i * 32'h0001_0203 + 32'h40);
      e   = (i % 3 == 0) ? 6'h0 : 6'((i * 5) % 64);
      pre = 32'hA5A5_0000 | 32'(i);
      ret = 32'hC0DE_0000 | 32'(i);
      h0  = {hb, 2'b00, tg, 1'b1, ty};
      wr(8'h04, pre);
      wr(8'h00, h0);
      chk("R3 req", 32'(lnk_req), 1);
      chk("R3 hdr0 out", lnk_hdr0, h0);
      chk("R3 hdr1 out", lnk_hdr1, pre);
      rd(8'h00, v); chk("R3 busy read", v, h0);
      rsp(e, ret);
      chk("R6 req drop", 32'(lnk_req), 0);
      chk("R10 irq on", 32'(irq), 1);
      rd(8'h00, v); chk("R6 busy clear", v, h0 & ~32'h8);
      rd(8'h70, v); chk("R7 status", v, exp_stat(e));
      rd(8'h04, v); chk("R9 hdr1", v, (ty == 3'd1 && e == 6'h0) ? ret : pre);
      wr(8'h70, 32'hFFFF_FFFF);
      rd(8'h70, v); chk("R8 clear all", v, 0);
      chk("R10 irq off", 32'(irq), 0);
    end

    // R5 writes ignored while busy
    wr(8'h04, 32'h0000_1111); wr(8'h08, 32'h0000_2222); wr(8'h0C, 32'h0000_3333);
    wr(8'h00, 32'h00AB_CD1C);
    wr(8'h04, 32'hDEAD_0001); wr(8'h08, 32'hDEAD_0002); wr(8'h0C, 32'hDEAD_0003);
    wr(8'h00, 32'hDEAD_0005);
    rd(8'h00, v); chk("R5 hdr0", v, 32'h00AB_CD1C);
    rd(8'h04, v); chk("R5 hdr1", v, 32'h0000_1111);
    rd(8'h08, v); chk("R5 hdr2", v, 32'h0000_2222);
    rd(8'h0C, v); chk("R5 data", v, 32'h0000_3333);
    rsp(6'h0, 32'h7777_7777);
    rd(8'h04, v); chk("R9 kind4 keeps", v, 32'h0000_1111);
    wr(8'h70, 32'hFFFF_FFFF);

    // R11 response while idle: kind 1 stored, no start
    wr(8'h00, 32'h0000_0011);
    rsp(6'h3F, 32'h1234_5678);
    rd(8'h04, v); chk("R11 hdr1", v, 32'h0000_1111);
    rd(8'h70, v); chk("R11 stat", v, 0);
    rd(8'h00, v); chk("R11 busy", v, 32'h0000_0011);
    chk("R11 irq", 32'(irq), 0);

    // R8 partial clear
    wr(8'h00, 32'h0000_0008);
    rsp(6'h3F, 32'h0);
    wr(8'h70, 32'h1000_0000);
    rd(8'h70, v); chk("R8 partial", v, 32'h0000_0077);
    chk("R10 irq err only", 32'(irq), 1);
    wr(8'h70, 32'h0000_0022);
    rd(8'h70, v); chk("R8 partial2", v, 32'h0000_0055);
    wr(8'h70, 32'hFFFF_FFFF);

    // R8 set wins over a clear in the same cycle
    wr(8'h00, 32'h0000_0008);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h70; bus_wdata = 32'hFFFF_FFFF;
    lnk_rsp = 1'b1; lnk_err = 6'h01;
    @(negedge clk);
    bus_wr = 1'b0; lnk_rsp = 1'b0; lnk_err = '0;
    rd(8'h70, v); chk("R8 set wins", v, 32'h1000_0001);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule